// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves data words from one clock domain to another through a power-of-two register array. The producer writes on its own clock. The consumer reads on a second clock that has no fixed relation to the first. The write and read pointers are one bit wider than the address. Each pointer crosses into the opposite domain as Gray code through a chain of flip-flops. Because of this, every status flag is produced in the domain of the port that uses it.

A static select input picks one of two read styles on the consumer side.

- **Look-ahead style:** the oldest word is moved into the output register without being asked for. A ready flag then says the register holds a fresh word. Asserting the read request consumes that word, and the next word (if any) replaces it on the same edge.
- **Standard style:** the flag says only that memory holds an unread word. The read request copies that word into the output register on the clock edge it is sampled.

In both styles a word that has reached the output register no longer counts against memory capacity. The producer sees a single space-available flag.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is asserted and right after it is released, rd_flag is 0, wr_ready is 1 and rd_data is all zeros, in either read style.
- R2: In standard style (fwft_mode = 0), after a write into an empty FIFO, rd_flag is still 0 after the first rising rd_clk edge that follows the write. It is 1 after the second such edge.
- R3: In look-ahead style (fwft_mode = 1), after a write into an empty FIFO, rd_flag stays 0 and rd_data keeps its old value through the second rising rd_clk edge after the write. On the third edge, rd_flag becomes 1 and rd_data shows the word.
- R4: In look-ahead style, an rd_clk edge with rd_en = 1 and rd_flag = 1 consumes the word in rd_data. On that same edge, the next stored word is loaded and rd_flag stays 1; if no word is stored, rd_flag goes to 0 and rd_data holds. With rd_en = 0, rd_flag and rd_data hold.
- R5: In standard style, an rd_clk edge with rd_en = 1 and rd_flag = 1 loads the oldest unread word into rd_data. Words come out in the order they were written, and rd_data changes at no other time.
- R6: A read request while rd_flag = 0 has no effect in either style. rd_data holds, and no stored word is skipped or consumed.
- R7: wr_ready goes to 0 exactly when 2^ADDR_W words sit in memory. A word already moved into rd_data is not counted, so look-ahead style holds 2^ADDR_W + 1 words in total.
- R8: A write request while wr_ready = 0 is dropped and never appears at the read side.
- R9: When a read frees a location of a full FIFO, wr_ready is still 0 after the first rising wr_clk edge that follows the read. It is 1 after the second such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock, asynchronous to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | Read style: 1 = look-ahead, 0 = standard; change only under reset |
| wr_en | input | 1 | Write request, sampled on wr_clk |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | 1 = at least one memory location is free (wr_clk domain) |
| rd_en | input | 1 | Read request, sampled on rd_clk |
| rd_data | output | DATA_W | Output register |
| rd_flag | output | 1 | Look-ahead: fresh word in rd_data; standard: unread word in memory (rd_clk domain) |

## Verification
The bench counts clock edges across both domains to confirm the latencies: two read edges to the standard-style flag, three to the look-ahead presentation, and two write edges to recover space. A design with one synchronizer stage too few or too many fails on one of these counts. It fills the memory, then offers one more word and drains everything, so a design that stored the extra word or let the pointers collide shows up as an extra or a corrupted word. In look-ahead style it checks that the FIFO holds one word more than its depth, which catches a design that still counts the output register as occupied. It issues reads while the flag is low and checks that nothing is lost when the next word arrives.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   typedef enum logic {
      RD_STANDARD  = 1'b0,
      RD_LOOKAHEAD = 1'b1
   } rd_style_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_ADDR_W      = 2;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   // read port is combinational; the consumer side registers it
   assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int ADDR_W = 4
) (
   input  logic            wr_clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ADDR_W:0] rq_gray,
   output logic [ADDR_W:0] wr_bin,
   output logic [ADDR_W:0] wr_gray,
   output logic            we,
   output logic            wr_ready
);

   logic [ADDR_W:0] bin_q;
   logic [ADDR_W:0] gray_q;
   logic [ADDR_W:0] bin_nx;
   logic [ADDR_W:0] full_pattern;
   logic            full;

   // full: same address, opposite wrap, seen in Gray form
   assign full_pattern = {~rq_gray[ADDR_W:ADDR_W-1], rq_gray[ADDR_W-2:0]};
   assign full         = (gray_q == full_pattern);
   assign we           = wr_en && !full;
   assign bin_nx       = bin_q + 1'b1;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else if (we) begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   assign wr_bin   = bin_q;
   assign wr_gray  = gray_q;
   assign wr_ready = !full;

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              fwft_mode,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wq_gray,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W:0]   rd_bin,
   output logic [ADDR_W:0]   rd_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_flag
);

   import dcf_pkg::*;

   rd_style_e         style;
   logic [ADDR_W:0]   bin_q;
   logic [ADDR_W:0]   gray_q;
   logic [ADDR_W:0]   bin_nx;
   logic [DATA_W-1:0] data_q;
   logic              avail;
   logic              fetch;
   logic              ready_q;

   assign style  = rd_style_e'(fwft_mode);
   assign avail  = (gray_q != wq_gray);
   assign bin_nx = bin_q + 1'b1;

   always_comb begin
      case (style)
         RD_LOOKAHEAD: fetch = avail && (!ready_q || rd_en);
         default:      fetch = avail && rd_en;
      endcase
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else if (fetch) begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)     data_q <= '0;
      else if (fetch) data_q <= mem_q;
   end

   // look-ahead presentation flag; idle in standard style
   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)                     ready_q <= 1'b0;
      else if (style != RD_LOOKAHEAD) ready_q <= 1'b0;
      else if (fetch)                 ready_q <= 1'b1;
      else if (rd_en)                 ready_q <= 1'b0;
   end

   assign rd_flag = (style == RD_LOOKAHEAD) ? ready_q : avail;
   assign rd_bin  = bin_q;
   assign rd_gray = gray_q;
   assign rd_data = data_q;

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              fwft_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_flag
);

   localparam int PTR_W = ADDR_W + 1;

   generate
      if (ADDR_W < dcf_pkg::MIN_ADDR_W) begin : g_bad_addr
         $error("dcf_fifo: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < dcf_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
         $error("dcf_fifo: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dcf_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [PTR_W-1:0]  wr_bin;
   logic [PTR_W-1:0]  wr_gray;
   logic [PTR_W-1:0]  rd_bin;
   logic [PTR_W-1:0]  rd_gray;
   logic [PTR_W-1:0]  wq_gray;
   logic [PTR_W-1:0]  rq_gray;
   logic [DATA_W-1:0] mem_q;
   logic              we;

   dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
      .wr_clk   (wr_clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rq_gray  (rq_gray),
      .wr_bin   (wr_bin),
      .wr_gray  (wr_gray),
      .we       (we),
      .wr_ready (wr_ready)
   );

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rd2wr (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rd_gray),
      .q     (rq_gray)
   );

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wr2rd (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wr_gray),
      .q     (wq_gray)
   );

   dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wr_clk (wr_clk),
      .we     (we),
      .waddr  (wr_bin[ADDR_W-1:0]),
      .wdata  (wr_data),
      .raddr  (rd_bin[ADDR_W-1:0]),
      .rdata  (mem_q)
   );

   dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .fwft_mode (fwft_mode),
      .rd_en     (rd_en),
      .wq_gray   (wq_gray),
      .mem_q     (mem_q),
      .rd_bin    (rd_bin),
      .rd_gray   (rd_gray),
      .rd_data   (rd_data),
      .rd_flag   (rd_flag)
   );

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              fwft_mode,
   input logic              rd_en,
   input logic              wr_ready,
   input logic              rd_flag,
   input logic [DATA_W-1:0] rd_data,
   input logic [ADDR_W:0]   wr_bin,
   input logic [ADDR_W:0]   rd_bin
);

   localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1 << ADDR_W);

   logic [ADDR_W:0] occ;
   always_comb occ = wr_bin - rd_bin;

   // R7: memory never holds more than its depth
   assert_no_overflow_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      occ <= DEPTH_V);

   // R8: a blocked write leaves the write pointer where it was
   assert_drop_blocked_write_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_ready |=> $stable(wr_bin));

   // R6: the read pointer never runs past the write pointer
   assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      occ <= DEPTH_V);

   // R6: standard style with the flag low consumes nothing
   assert_std_idle_read_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && !rd_flag) |=> $stable(rd_bin));

   // R5: standard-style output changes only on an accepted read
   assert_std_output_hold_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && !(rd_en && rd_flag)) |=> $stable(rd_data));

   // R4: a presented word waits until it is taken
   assert_la_present_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (fwft_mode && rd_flag && !rd_en) |=> (rd_flag && $stable(rd_data)));

endmodule

bind dcf_fifo dcf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wr_clk    (wr_clk),
   .rd_clk    (rd_clk),
   .rst_n     (rst_n),
   .fwft_mode (fwft_mode),
   .rd_en     (rd_en),
   .wr_ready  (wr_ready),
   .rd_flag   (rd_flag),
   .rd_data   (rd_data),
   .wr_bin    (wr_bin),
   .rd_bin    (rd_bin)
);

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int RD_HALF    = 7;
   localparam int DATA_W     = 32;
   localparam int ADDR_W     = 4;
   localparam int DEPTH      = 1 << ADDR_W;

   // each entry: {rd_flag expected after popping it, word written}
   localparam logic [32:0] VEC [8] = '{
      {1'b1, 32'h0000_0001}, {1'b1, 32'hFFFF_FFFE}, {1'b1, 32'h8000_0000},
      {1'b1, 32'h1234_5678}, {1'b1, 32'hAAAA_5555}, {1'b1, 32'h0F0F_F0F0},
      {1'b1, 32'h7FFF_FFFF}, {1'b0, 32'hC0DE_CAFE}
   };

   logic              wr_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fwft_mode = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic              wr_ready;
   logic              rd_flag;
   logic [DATA_W-1:0] rd_data;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   dcf_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dcf_fifo (
      .wr_clk    (wr_clk),
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .fwft_mode (fwft_mode),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_ready  (wr_ready),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .rd_flag   (rd_flag)
   );

   // write edges fall on odd times, read edges on even times
   initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   initial begin
      #2;
      forever begin
         rd_clk = 1'b1; #RD_HALF;
         rd_clk = 1'b0; #RD_HALF;
      end
   end

   function automatic logic [31:0] pat(input int i);
      return (32'(i) * 32'h0101_0103) ^ 32'h5A00_00C3;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0;
      wr_en = 1'b0;
      rd_en = 1'b0;
      #1 fwft_mode = mode;
      repeat (2) @(posedge wr_clk);
      #2 rst_n = 1'b1;
      repeat (2) @(posedge rd_clk);
      #2;
   endtask

   task automatic push(input logic [31:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      @(posedge wr_clk);
      wr_en <= 1'b0;
      #2;
   endtask

   task automatic pop();
      rd_en = 1'b1;
      @(posedge rd_clk);
      rd_en <= 1'b0;
      #2;
   endtask

   task automatic settle();
      repeat (4) @(posedge rd_clk);
      repeat (3) @(posedge wr_clk);
      #2;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // ---------------- standard style ----------------
      do_reset(1'b0);
      chk("R1 std rd_flag", 32'(rd_flag), 32'd0);
      chk("R1 std wr_ready", 32'(wr_ready), 32'd1);
      chk("R1 std rd_data", rd_data, 32'd0);

      // R2 latency of the memory-not-empty flag
      wr_data = 32'h1111_2222;
      wr_en   = 1'b1;
      @(posedge wr_clk);
      wr_en <= 1'b0;
      @(posedge rd_clk); #2 chk("R2 flag after edge 1", 32'(rd_flag), 32'd0);
      @(posedge rd_clk); #2 chk("R2 flag after edge 2", 32'(rd_flag), 32'd1);
      chk("R5 no load before read", rd_data, 32'd0);
      pop();
      chk("R5 word loaded on read", rd_data, 32'h1111_2222);
      chk("R5 flag after last word", 32'(rd_flag), 32'd0);
      pop();
      chk("R6 std idle read holds data", rd_data, 32'h1111_2222);

      // R7 / R8 / R9 fill, overflow attempt, space recovery
      for (int i = 0; i < DEPTH; i++) begin
         chk("R7 ready while not full", 32'(wr_ready), 32'd1);
         push(pat(i));
      end
      chk("R7 not ready when full", 32'(wr_ready), 32'd0);
      push(32'hDEAD_BEEF);
      settle();
      chk("R8 still full after dropped write", 32'(wr_ready), 32'd0);
      rd_en = 1'b1;
      @(posedge rd_clk);
      rd_en <= 1'b0;
      @(posedge wr_clk); #2 chk("R9 ready after wr edge 1", 32'(wr_ready), 32'd0);
      @(posedge wr_clk); #2 chk("R9 ready after wr edge 2", 32'(wr_ready), 32'd1);
      chk("R5 first of full drain", rd_data, pat(0));
      for (int i = 1; i < DEPTH; i++) begin
         pop();
         chk("R5 drain order", rd_data, pat(i));
      end
      settle();
      chk("R8 dropped word never readable", 32'(rd_flag), 32'd0);
      pop();
      chk("R6 std read on empty holds", rd_data, pat(DEPTH-1));

      // ---------------- look-ahead style ----------------
      do_reset(1'b1);
      chk("R1 la rd_flag", 32'(rd_flag), 32'd0);
      chk("R1 la wr_ready", 32'(wr_ready), 32'd1);
      chk("R1 la rd_data", rd_data, 32'd0);

      // R3 latency of presentation
      wr_data = 32'h3333_4444;
      wr_en   = 1'b1;
      @(posedge wr_clk);
      wr_en <= 1'b0;
      @(posedge rd_clk); #2 chk("R3 flag after edge 1", 32'(rd_flag), 32'd0);
      @(posedge rd_clk); #2 chk("R3 flag after edge 2", 32'(rd_flag), 32'd0);
      chk("R3 data before edge 3", rd_data, 32'd0);
      @(posedge rd_clk); #2 chk("R3 flag after edge 3", 32'(rd_flag), 32'd1);
      chk("R3 data on edge 3", rd_data, 32'h3333_4444);
      pop();
      chk("R4 flag drops when nothing left", 32'(rd_flag), 32'd0);
      chk("R4 data held when nothing left", rd_data, 32'h3333_4444);
      pop();
      chk("R6 la idle read holds data", rd_data, 32'h3333_4444);
      push(32'h5555_6666);
      settle();
      chk("R6 next word not skipped flag", 32'(rd_flag), 32'd1);
      chk("R6 next word not skipped data", rd_data, 32'h5555_6666);
      pop();

      // R4 vector table, streamed back-to-back
      for (int i = 0; i < 8; i++) push(VEC[i][31:0]);
      settle();
      for (int i = 0; i < 8; i++) begin
         chk("R4 table flag before pop", 32'(rd_flag), 32'd1);
         chk("R4 table data", rd_data, VEC[i][31:0]);
         pop();
         chk("R4 table flag after pop", 32'(rd_flag), 32'(VEC[i][32]));
      end

      // R7 look-ahead capacity is depth plus output register
      push(32'hF00D_0000);
      settle();
      chk("R7 head presented", 32'(rd_flag), 32'd1);
      for (int i = 1; i <= DEPTH; i++) begin
         chk("R7 la ready while memory has room", 32'(wr_ready), 32'd1);
         push(pat(100 + i));
      end
      chk("R7 la full after depth+1 words", 32'(wr_ready), 32'd0);
      settle();
      chk("R7 la head kept", rd_data, 32'hF00D_0000);
      for (int i = 1; i <= DEPTH; i++) begin
         pop();
         chk("R7 la drain order", rd_data, pat(100 + i));
      end
      pop();
      chk("R4 la empty after drain", 32'(rd_flag), 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule